// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block is an 8-bit counter driven by a single external input pin. In event mode it adds one for every selected edge on the pin, so software can count external occurrences such as a sensor closing. In gated mode it adds one for every tick of a free-running divide-by-64 prescaler, but only while the pin sits at its active level. The final count then measures how long the pin was active, in units of 64 clocks.

Software reaches the block through a small register port. It can set the mode and the polarity, turn the counter on or off, preload or read the count, and clear two sticky flags. The overflow flag is set when the count wraps from 0xFF to 0x00. Preloading the two's complement of N therefore gives an overflow after exactly N counts. The input-edge flag marks a qualifying edge on the pin. Each flag drives its own interrupt output, and each interrupt has its own enable.

Top module: `pulse_acc`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0x00, the control register reads 0x00, both flags read 0 and both interrupt outputs are low.
- R2: While the enable bit is 0, the count keeps its value and the input-edge flag is not set, whatever the pin does. A software write to the count is still accepted.
- R3: In event mode (mode bit 0), each selected pin edge adds one to the count. Polarity 1 selects rising edges and polarity 0 selects falling edges.
- R4: The pin passes through a two-flop synchronizer. A selected edge therefore updates the count on the third rising clock edge after the pin changes.
- R5: In gated mode (mode bit 1), the count adds one on each prescaler tick while the synchronized pin is at the active level: high for polarity 1, low for polarity 0. The prescaler ticks once every 64 clocks, runs freely from reset and is never restarted, so an active window of exactly 64·M clocks adds exactly M.
- R6: A count step from 0xFF to 0x00 sets the overflow flag. After a preload of 256−N, the flag is set at the N-th count and not before.
- R7: The input-edge flag is set by the counted edge in event mode. In gated mode it is set by the edge that ends the active level: falling for polarity 1, rising for polarity 0.
- R8: Each interrupt output equals its flag ANDed with its enable bit. Writing 1 to a flag bit of the status register clears that flag and leaves the other flag unchanged. A set and a clear in the same cycle leave the flag set.
- R9: A software write to the count in the same cycle as an increment loads the written value. The discarded increment does not set the overflow flag.
- R10: The register map is as follows. Address 0 is control: bit 0 enable, bit 1 mode, bit 2 polarity, bit 3 overflow interrupt enable, bit 4 edge interrupt enable. Address 1 is status: bit 0 overflow, bit 1 input edge, both write-1-to-clear. Address 2 is the count. Address 3 reads 0. Reads are combinational from `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| edge_irq_o | output | 1 | Input-edge interrupt request |

## Verification
The hardest case to reach from the ports is a count write that lands in the same cycle as an increment, especially when the count holds 0xFF. The stimulus uses the fixed synchronizer latency to get there. It preloads 0xFF, raises the pin on a falling clock edge, and asserts the count write two falling edges later. The write then lands on exactly the clock edge where the increment takes effect. Gated-mode checks use active windows that are whole multiples of 64 clocks, so the expected count does not depend on the unknown phase of the free-running prescaler.

// File: rtl/pacc_pkg.sv
// Shared definitions for the pulse accumulator: register addresses and
// the control register layout. Assumes a 2-bit register address space.
package pacc_pkg;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CNT  = 2'd2,
        REG_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic edge_ie;
        logic ovf_ie;
        logic pol;
        logic mode;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/pacc_input_cond.sv
// Input conditioner: synchronizes the asynchronous pin through a flop
// chain and reports the synchronized level plus single-cycle rise/fall
// pulses. Assumes SYNC_STAGES >= 2.
module pacc_input_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign level_o = sync_q[SYNC_STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/pacc_prescaler.sv
// Free-running clock divider: emits a one-cycle tick every DIV clocks,
// counting from reset and never restarted. Assumes DIV >= 2.
module pacc_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Advance the divider and wrap after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                 div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/pacc_counter.sv
// Loadable up-counter: a load beats an increment; reports a wrap pulse
// when an accepted increment steps from all ones to zero.
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    // Load, increment or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i & ~load_i & (&cnt_q);
endmodule

// File: rtl/pulse_acc.sv
// Pulse accumulator top: counts selected pin edges (event mode) or
// prescaler ticks while the pin is active (gated mode), with sticky
// overflow and input-edge flags and per-flag interrupt enables.
// Assumes a synchronous register port with combinational reads.
module pulse_acc
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRESCALE    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              ovf_irq_o,
    output logic              edge_irq_o
);
    ctrl_t            ctrl_q;
    logic             level, rise, fall, tick;
    logic             cnt_wr, ctrl_wr, stat_wr;
    logic             evt_edge, end_edge, active, inc, edge_set, wrap;
    logic [CNT_W-1:0] cnt;
    logic             ovf_q, edge_q;

    pacc_input_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    pacc_prescaler #(.DIV(PRESCALE)) pre_i (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign ctrl_wr = wr_en_i & (wr_addr_i == REG_CTRL);
    assign stat_wr = wr_en_i & (wr_addr_i == REG_STAT);
    assign cnt_wr  = wr_en_i & (wr_addr_i == REG_CNT);

    assign evt_edge = ctrl_q.pol ? rise : fall;
    assign end_edge = ctrl_q.pol ? fall : rise;
    assign active   = (level == ctrl_q.pol);
    assign inc      = ctrl_q.en & (ctrl_q.mode ? (active & tick) : evt_edge);
    assign edge_set = ctrl_q.en & (ctrl_q.mode ? end_edge : evt_edge);

    pacc_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_wr), .load_val_i(wr_data_i),
        .inc_i(inc), .cnt_o(cnt), .wrap_o(wrap)
    );

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end

    // Sticky flags: set wins over a write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            ovf_q  <= wrap     | (ovf_q  & ~(stat_wr & wr_data_i[0]));
            edge_q <= edge_set | (edge_q & ~(stat_wr & wr_data_i[1]));
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr_i)
            REG_CTRL: rd_data_o = CNT_W'(ctrl_q);
            REG_STAT: rd_data_o = CNT_W'({edge_q, ovf_q});
            REG_CNT:  rd_data_o = cnt;
            default:  rd_data_o = '0;
        endcase
    end

    assign ovf_irq_o  = ovf_q  & ctrl_q.ovf_ie;
    assign edge_irq_o = edge_q & ctrl_q.edge_ie;

    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !cnt_wr) |=> (cnt == $past(cnt)));
    p_gated_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && ctrl_q.mode) |-> tick);
    p_wrap_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && (&cnt)) |=> ovf_q);
    p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_set |=> edge_q);
    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_irq_o) |-> ctrl_q.ovf_ie);
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_data_i)));
endmodule

// File: tb/pulse_acc_tb_top.sv
module pulse_acc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [1:0] rd_addr_i = 2'd0;
    logic [7:0] rd_data_o;
    logic       ovf_irq_o, edge_irq_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pulse_acc dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .ovf_irq_o(ovf_irq_o), .edge_irq_o(edge_irq_o)
    );

    // Control values: en=1, mode=2, pol=4, ovf_ie=8, edge_ie=16 (R10)
    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #1 d = rd_data_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_i = ~pin_i; idle(4);
            pin_i = ~pin_i; idle(4);
        end
        idle(4);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reset regs", v, 8'h00);
        end
        chk("R1 reset irqs", {6'd0, ovf_irq_o, edge_irq_o}, 8'h00);
    endtask

    task automatic t_event;
        logic [7:0] v;
        wr(2'd0, 8'h05);              // en, rising
        pulses(5);
        rd(2'd2, v); chk("R3 rising edges counted", v, 8'd5);
        wr(2'd0, 8'h01);              // en, falling
        wr(2'd2, 8'h00);
        pulses(3);
        rd(2'd2, v); chk("R3 falling edges counted", v, 8'd3);
        rd(2'd0, v); chk("R10 control readback", v, 8'h01);
    endtask

    task automatic t_latency;
        logic [7:0] v;
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h00);
        pin_i = 1'b1;
        idle(2);
        rd(2'd2, v); chk("R4 no count before third edge", v, 8'd0);
        idle(1);
        rd(2'd2, v); chk("R4 count on third edge", v, 8'd1);
        pin_i = 1'b0; idle(4);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(2'd0, 8'h04);              // disabled, rising
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h22);
        pulses(3);
        rd(2'd2, v); chk("R2 count held while disabled", v, 8'h22);
        rd(2'd1, v); chk("R2 no edge flag while disabled", v, 8'h00);
    endtask

    task automatic t_preload;
        logic [7:0] v;
        wr(2'd0, 8'h05);
        wr(2'd2, 8'hFD);
        wr(2'd1, 8'h03);
        pulses(2);
        rd(2'd2, v); chk("R6 count before overflow", v, 8'hFF);
        rd(2'd1, v); chk("R6 no overflow after N-1", v & 8'h01, 8'h00);
        pulses(1);
        rd(2'd2, v); chk("R6 wrapped count", v, 8'h00);
        rd(2'd1, v); chk("R6 overflow after N", v & 8'h01, 8'h01);
        chk("R8 ovf irq masked", {7'd0, ovf_irq_o}, 8'd0);
        wr(2'd0, 8'h0D);
        chk("R8 ovf irq enabled", {7'd0, ovf_irq_o}, 8'd1);
        wr(2'd1, 8'h01);
        chk("R8 ovf irq cleared", {7'd0, ovf_irq_o}, 8'd0);
        rd(2'd1, v); chk("R8 edge flag kept on ovf clear", v, 8'h02);
        wr(2'd0, 8'h15);
        chk("R8 edge irq enabled", {7'd0, edge_irq_o}, 8'd1);
        wr(2'd1, 8'h02);
        chk("R8 edge irq cleared", {7'd0, edge_irq_o}, 8'd0);
    endtask

    task automatic t_gated;
        logic [7:0] v;
        wr(2'd0, 8'h07);              // en, gated, active high
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h03);
        pin_i = 1'b1;
        idle(10);
        rd(2'd1, v); chk("R7 rise does not flag in gated high", v, 8'h00);
        idle(246);
        pin_i = 1'b0;
        idle(300);
        rd(2'd2, v); chk("R5 gated high 256 clocks", v, 8'd4);
        rd(2'd1, v); chk("R7 trailing edge flags in gated", v, 8'h02);
        pin_i = 1'b1;
        wr(2'd0, 8'h03);              // en, gated, active low
        idle(4);
        wr(2'd2, 8'h00);
        pin_i = 1'b0;
        idle(128);
        pin_i = 1'b1;
        idle(200);
        rd(2'd2, v); chk("R5 gated low 128 clocks", v, 8'd2);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        wr(2'd0, 8'h05);
        pin_i = 1'b0; idle(4);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h03);
        pin_i = 1'b1;
        idle(2);
        wr(2'd2, 8'h40);
        idle(4);
        rd(2'd2, v); chk("R9 write beats increment", v, 8'h40);
        rd(2'd1, v); chk("R9 no overflow from lost increment", v & 8'h01, 8'h00);
        pin_i = 1'b0; idle(4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_event();
        t_latency();
        t_disabled();
        t_preload();
        t_gated();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule